// File: doc/BRIEF.md
# Dual Timer Count-Source Selector

This block contains two 16-bit free-running up-counters, timer 0 and timer 1. Each one chooses what makes it advance from four candidates. The candidates are the timer prescaler tick, its own external count pin, a CPU activity strobe and the peripheral prescaler tick. For CPU activity, timer 1 counts ROM fetch requests, which gives one count per fetched byte. Timer 0 counts executed-instruction strobes. Both counters can therefore measure how fast a self-timed processor is working over a chosen window.

Software uses one register write port. Through it, software sets both source selects in a control byte, loads either counter and clears the overflow flags. A power-down input blocks every clock-derived and CPU-derived event. A counter that is set to its external pin still counts, wraps and raises its flag, so a pin can wake the system on overflow.

Top module: `tmr_src_pair`

## Requirements
- R1: After reset both counters read 0, both overflow flags are 0, and both source selects are 00.
- R2: A write to address 0 sets the timer 1 select from data bits 7:6 and the timer 0 select from data bits 5:4. Select 00 counts the timer prescaler tick, one count per cycle that psc_tick_i is high.
- R3: Select 11 counts the peripheral prescaler tick, one count per cycle that per_tick_i is high.
- R4: Timer 1 with select 10 counts ROM requests, one count per cycle that rom_req_i is high, which is one count per fetched byte. A 3-cycle burst adds 3.
- R5: Timer 0 with select 10 counts instructions, one count per cycle that instr_i is high.
- R6: Select 01 counts rising edges of the timer's external pin (ext_pin_i bit 0 for timer 0, bit 1 for timer 1) after a two-flop synchronizer. Each edge gives exactly one count, and the count is visible 3 clock edges after the pin rises.
- R7: While pwr_down_i is high, prescaler ticks and CPU strobes do not advance either counter. External-pin counting continues.
- R8: A wrap from 0xFFFF to 0x0000 sets that timer's sticky overflow flag in the same cycle. A write to address 3 clears flag n only where data bit n is 1. Writing 0 leaves the flag set.
- R9: A write to address 1 loads timer 0 and a write to address 2 loads timer 1 from data bits 15:0. A load in the same cycle as an increment wins over the increment.
- R10: Events of a source that is not selected have no effect on the counter.
- R11: In power-down, a timer on its external pin still wraps and sets its overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| psc_tick_i | input | 1 | Timer prescaler tick enable |
| per_tick_i | input | 1 | Peripheral prescaler tick enable |
| ext_pin_i | input | 2 | External count pins, bit 0 timer 0, bit 1 timer 1 |
| rom_req_i | input | 1 | ROM fetch request strobe, one cycle per byte |
| instr_i | input | 1 | Instruction-executed strobe |
| pwr_down_i | input | 1 | Power-down flag |
| wr_en_i | input | 1 | Register write enable |
| wr_addr_i | input | 2 | 0 control, 1 timer 0, 2 timer 1, 3 flag clear |
| wr_data_i | input | 16 | Register write data |
| cnt0_o | output | 16 | Timer 0 count |
| cnt1_o | output | 16 | Timer 1 count |
| ovf_o | output | 2 | Overflow flags, bit 0 timer 0, bit 1 timer 1 |

## Verification
Tick, strobe and register-write effects appear at the first rising edge that samples them. The bench drives each of these events for one negative-edge-to-negative-edge interval and reads the result at the next falling edge. External-pin edges go through two synchronizer flops and an edge-detect flop, so the count lands on the third edge. The bench holds each pin level for two cycles and waits at least four cycles after the last edge before it reads. The sweep covers every select for both timers, with and without power-down, and uses a different event count for each source so that a wrong source shows as a wrong number.

// File: rtl/tmr_src_pkg.sv
package tmr_src_pkg;
  typedef enum logic [1:0] {
    SRC_PSC = 2'b00,
    SRC_PIN = 2'b01,
    SRC_CPU = 2'b10,
    SRC_PER = 2'b11
  } src_e;

  localparam int unsigned ADDR_W   = 2;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_CNT0 = 2'd1;
  localparam logic [ADDR_W-1:0] A_CNT1 = 2'd2;
  localparam logic [ADDR_W-1:0] A_CLR  = 2'd3;
  // control byte: timer n select at bits (5+2n):(4+2n)
  localparam int unsigned SEL_LSB  = 4;
endpackage

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

  // R6
  one_count_per_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/tmr_src_mux.sv
module tmr_src_mux
  import tmr_src_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] sel_i,
  input  logic       pwr_down_i,
  input  logic       psc_tick_i,
  input  logic       pin_rise_i,
  input  logic       cpu_stb_i,
  input  logic       per_tick_i,
  output logic       inc_o
);
  logic raw;

  always_comb begin
    unique case (src_e'(sel_i))
      SRC_PSC: raw = psc_tick_i;
      SRC_PIN: raw = pin_rise_i;
      SRC_CPU: raw = cpu_stb_i;
      SRC_PER: raw = per_tick_i;
      default: raw = 1'b0;
    endcase
  end

  // pin path survives power-down, clocked sources do not
  assign inc_o = (src_e'(sel_i) == SRC_PIN) ? raw : (raw & ~pwr_down_i);

  // R7
  pd_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_down_i && sel_i != 2'b01) |-> !inc_o);
  // R10
  unselected_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i != 2'b01 && !psc_tick_i && !cpu_stb_i && !per_tick_i) |-> !inc_o);
endmodule

// File: rtl/tmr_cnt_unit.sv
module tmr_cnt_unit #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic             wrap;

  assign wrap = inc_i & ~wr_i & (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (wr_i)       cnt_q <= wdata_i;
      else if (inc_i) cnt_q <= cnt_q + 1'b1;
      // set wins over a same-cycle clear
      if (wrap)       ovf_q <= 1'b1;
      else if (clr_i) ovf_q <= 1'b0;
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;

  // R9
  wr_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> cnt_q == $past(wdata_i));
  // R2
  inc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !wr_i) |=> cnt_q == $past(cnt_q) + 1'b1);
  // R10
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !wr_i) |=> $stable(cnt_q));
  // R8
  wrap_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !wr_i && cnt_q == CNT_MAX) |=> (ovf_q && cnt_q == '0));
  // R8
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !clr_i) |=> ovf_q);
endmodule

// File: rtl/tmr_src_pair.sv
module tmr_src_pair
  import tmr_src_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             psc_tick_i,
  input  logic             per_tick_i,
  input  logic [1:0]       ext_pin_i,
  input  logic             rom_req_i,
  input  logic             instr_i,
  input  logic             pwr_down_i,
  input  logic             wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] cnt0_o,
  output logic [CNT_W-1:0] cnt1_o,
  output logic [1:0]       ovf_o
);
  localparam int unsigned NUM_TMR = 2;

  logic [NUM_TMR-1:0][1:0]       sel_q;
  logic [NUM_TMR-1:0]            cpu_stb;
  logic [NUM_TMR-1:0]            pin_rise;
  logic [NUM_TMR-1:0]            inc;
  logic [NUM_TMR-1:0]            cnt_wr;
  logic [NUM_TMR-1:0]            ovf_clr;
  logic [NUM_TMR-1:0][CNT_W-1:0] cnt;
  logic                          ctrl_wr;

  // timer 0 counts instructions, timer 1 counts fetched bytes
  assign cpu_stb = {rom_req_i, instr_i};
  assign ctrl_wr = wr_en_i && (wr_addr_i == A_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
    end else if (ctrl_wr) begin
      for (int i = 0; i < NUM_TMR; i++)
        sel_q[i] <= wr_data_i[SEL_LSB+2*i +: 2];
    end
  end

  generate
    for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
      localparam logic [ADDR_W-1:0] CNT_ADDR = (g == 0) ? A_CNT0 : A_CNT1;

      assign cnt_wr[g]  = wr_en_i && (wr_addr_i == CNT_ADDR);
      assign ovf_clr[g] = wr_en_i && (wr_addr_i == A_CLR) && wr_data_i[g];

      tmr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pin_i  (ext_pin_i[g]),
        .rise_o (pin_rise[g])
      );

      tmr_src_mux u_mux (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .sel_i      (sel_q[g]),
        .pwr_down_i (pwr_down_i),
        .psc_tick_i (psc_tick_i),
        .pin_rise_i (pin_rise[g]),
        .cpu_stb_i  (cpu_stb[g]),
        .per_tick_i (per_tick_i),
        .inc_o      (inc[g])
      );

      tmr_cnt_unit #(.CNT_W(CNT_W)) u_cnt (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .inc_i   (inc[g]),
        .wr_i    (cnt_wr[g]),
        .wdata_i (wr_data_i),
        .clr_i   (ovf_clr[g]),
        .cnt_o   (cnt[g]),
        .ovf_o   (ovf_o[g])
      );
    end
  endgenerate

  assign cnt0_o = cnt[0];
  assign cnt1_o = cnt[1];

  // R1
  sel_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(ctrl_wr) |-> $stable(sel_q));
  // R11
  pd_pin_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_down_i && sel_q[1] == 2'b01 && pin_rise[1] && !cnt_wr[1]
     && cnt1_o == '1) |=> ovf_o[1]);
endmodule

// File: tb/sim_tmr_src_pair.sv
module sim_tmr_src_pair;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psc_tick = 0, per_tick = 0, rom_req = 0, instr = 0, pwr_down = 0;
  logic [1:0]  ext_pin = 2'b00;
  logic        wr_en = 0;
  logic [1:0]  wr_addr = 0;
  logic [15:0] wr_data = 0;
  logic [15:0] cnt0, cnt1;
  logic [1:0]  ovf;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tmr_src_pair u0 (
    .clk_i(clk), .rst_ni(rst_n), .psc_tick_i(psc_tick), .per_tick_i(per_tick),
    .ext_pin_i(ext_pin), .rom_req_i(rom_req), .instr_i(instr),
    .pwr_down_i(pwr_down), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .cnt0_o(cnt0), .cnt1_o(cnt1), .ovf_o(ovf)
  );

  localparam int N_PSC = 3, N_PIN = 5, N_INS = 6, N_ROM = 7, N_PER = 9;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_psc(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); psc_tick = 1; @(negedge clk); psc_tick = 0;
    end
  endtask

  task automatic pulse_per(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); per_tick = 1; @(negedge clk); per_tick = 0;
    end
  endtask

  task automatic pulse_ins(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); instr = 1; @(negedge clk); instr = 0;
    end
  endtask

  // byte bursts of 3, 2, 2 fetches, contiguous within a burst
  task automatic rom_bursts();
    int b[3] = '{3, 2, 2};
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); rom_req = 1;
      repeat (b[k] - 1) @(negedge clk);
      @(negedge clk); rom_req = 0;
      idle(2);
    end
  endtask

  task automatic pin_edges(logic [1:0] m, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ext_pin = m; idle(2);
      ext_pin = 2'b00; idle(2);
    end
    idle(4);
  endtask

  function automatic int exp_cnt(int t, int sel, bit pd);
    if (pd && sel != 1) return 0;
    case (sel)
      0: return N_PSC;
      1: return N_PIN;
      2: return (t == 0) ? N_INS : N_ROM;
      default: return N_PER;
    endcase
  endfunction

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    // R1 reset state
    chk("R1 cnt0", cnt0, 0);
    chk("R1 cnt1", cnt1, 0);
    chk("R1 ovf", ovf, 0);
    rst_n = 1; idle(2);
    pulse_psc(2);
    chk("R1 default select counts psc tick t0", cnt0, 2);
    chk("R1 default select counts psc tick t1", cnt1, 2);

    // R2 R3 R4 R5 R6 R7 R10 sweep: all selects, both timers, pd off/on
    for (int pd = 0; pd < 2; pd++) begin
      for (int s = 0; s < 4; s++) begin
        int s1 = 3 - s;
        wr(2'd0, 16'((s1 << 6) | (s << 4)));
        wr(2'd1, 16'h0000);
        wr(2'd2, 16'h0000);
        pwr_down = pd[0];
        pulse_psc(N_PSC);
        pulse_per(N_PER);
        pulse_ins(N_INS);
        rom_bursts();
        pin_edges(2'b11, N_PIN);
        pwr_down = 0;
        chk($sformatf("R2 R3 R4 R5 R6 R7 R10 t0 sel=%0d pd=%0d", s, pd),
            cnt0, exp_cnt(0, s, pd[0]));
        chk($sformatf("R2 R3 R4 R5 R6 R7 R10 t1 sel=%0d pd=%0d", s1, pd),
            cnt1, exp_cnt(1, s1, pd[0]));
      end
    end

    // R6 latency: count lands on the third edge after the pin rises
    wr(2'd0, 16'h0050);
    wr(2'd1, 16'h0000);
    @(negedge clk); ext_pin = 2'b01;
    idle(2);
    chk("R6 not yet after two edges", cnt0, 0);
    idle(1);
    chk("R6 counted on third edge", cnt0, 1);
    idle(3);
    chk("R6 held level counts once", cnt0, 1);
    ext_pin = 2'b00; idle(4);

    // R9 write wins over same-cycle increment
    wr(2'd0, 16'h0000);
    @(negedge clk); psc_tick = 1; wr_en = 1; wr_addr = 2'd1; wr_data = 16'h1234;
    @(negedge clk); psc_tick = 0; wr_en = 0;
    chk("R9 write priority t0", cnt0, 16'h1234);
    wr(2'd2, 16'hBEEF);
    chk("R9 load t1", cnt1, 16'hBEEF);

    // R8 wrap, sticky, write-one-to-clear
    wr(2'd1, 16'hFFFF);
    pulse_psc(1);
    chk("R8 wrap value", cnt0, 0);
    chk("R8 flag set", ovf, 2'b01);
    pulse_psc(1);
    chk("R8 flag sticky", ovf, 2'b01);
    wr(2'd3, 16'h0002);
    chk("R8 clearing other bit leaves flag", ovf, 2'b01);
    wr(2'd3, 16'h0000);
    chk("R8 writing zero leaves flag", ovf, 2'b01);
    wr(2'd3, 16'h0001);
    chk("R8 write one clears", ovf, 2'b00);

    // R11 pin overflow during power-down
    wr(2'd0, 16'h0040);
    wr(2'd2, 16'hFFFE);
    pwr_down = 1;
    pulse_psc(4);
    pin_edges(2'b10, 2);
    chk("R11 pd pin wrap value", cnt1, 0);
    chk("R11 pd pin flag", ovf, 2'b10);
    pwr_down = 0;

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule